// File: doc/BRIEF.md
# Chip-Select Timing Machine for a Multiplexed Address/Data Bus

This block drives one external memory or peripheral on a shared address/data local bus. A request from the internal bus, either one read or one write, is taken only while the machine is idle. The machine then runs the pins through a fixed order of phases. First the address is driven with the latch-enable strobe high. Next come optional setup cycles and a chip-select lead cycle. Then comes the strobe phase, in which the write enable or output enable is active. The pins move straight from address to data with no idle gap. The block ends every access with a single internal acknowledge pulse.

All timing counts quarter-phase ticks of the block clock. Four ticks make one bus cycle. The configuration inputs are latched when a request is accepted:

- latch-enable length L = `cfg_ale_len`+1 cycles
- setup S = `cfg_cs_setup` cycles
- wait count W = `cfg_wait_cnt`
- relax bit R = `cfg_relax`
- early-negation bit E = `cfg_early_neg`

The strobe phase lasts N = W+R+1 bus cycles. On a write with E set, chip select and write enable are released one tick early. With R set, one recovery cycle follows before the machine becomes ready again.

The machine has six states:

- ST_IDLE goes to ST_ADDR when a request is accepted.
- ST_ADDR goes to ST_SETUP after L cycles when S≠0, or to ST_CSLEAD when S=0.
- ST_SETUP goes to ST_CSLEAD after S cycles.
- ST_CSLEAD goes to ST_STROBE after one cycle.
- ST_STROBE goes to ST_RECOVER after N cycles when R=1, or to ST_IDLE when R=0.
- ST_RECOVER goes to ST_IDLE after one cycle.

Top module: `mux_bus_cs_timer`

## Requirements
- R1: Tick 1 is the first tick after the accepting clock edge. From tick 1, `bus_ale` is high for exactly 4·L ticks, where L = `cfg_ale_len`+1. During these ticks the latched address is on `bus_ad_out`, `bus_ad_oe` is 1 and `bus_cs_n` is 1.
- R2: `bus_cs_n` first goes low at tick 4·(L+S)+1, where S = `cfg_cs_setup`.
- R3: The active strobe first goes low exactly 4 ticks after `bus_cs_n` first goes low. For a write this strobe is `bus_we_n`; for a read it is `bus_oe_n`.
- R4: For a write, `bus_we_n` is low for 4·N−E ticks, where N = `cfg_wait_cnt`+`cfg_relax`+1. `bus_cs_n` is low for 4+4·N−E ticks. Both rise together.
- R5: For a read, `bus_oe_n` is low for 4·N ticks and `bus_ad_oe` is 0 throughout. E has no effect on a read. `bus_ad_oe` is 1 for exactly 4·(L+S+1) ticks.
- R6: For a write, the pins go from the address to the write data with no undriven tick. `bus_ad_oe` stays 1 for 4·(L+S+1+N) ticks.
- R7: `ack` is a single one-tick pulse. It falls in the last tick of the last strobe cycle, tick 4·(L+S+1+N). There is exactly one pulse per accepted request.
- R8: For a read, `rd_data` takes the value on `bus_ad_in` during the ack tick. It holds that value until the next read completes, including across writes.
- R9: `req_ready` stays 0 for 4·(L+S+1+N+R) ticks after acceptance, where R = `cfg_relax`.
- R10: A request is accepted only at a clock edge where `req_ready` is 1. A `req_valid` raised while busy is ignored: it produces no second acknowledge, no change to the timing and no later access.
- R11: After reset, `req_ready`=1, `bus_cs_n`=`bus_we_n`=`bus_oe_n`=1, and `bus_ale`=`ack`=`bus_ad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase tick clock (four ticks per bus cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe from the internal bus |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_W | Access address |
| req_wdata | input | BUS_W | Write data |
| req_ready | output | 1 | Idle; a request is accepted at this edge |
| cfg_wait_cnt | input | SCY_W | Wait-state count W |
| cfg_relax | input | 1 | Relaxed timing R: longer strobe, recovery cycle |
| cfg_early_neg | input | 1 | Early chip-select/write-enable release E |
| cfg_ale_len | input | ALE_W | Latch-enable length minus one |
| cfg_cs_setup | input | SET_W | Setup cycles before chip select |
| bus_ad_out | output | BUS_W | Shared pins, outgoing value |
| bus_ad_oe | output | 1 | Shared pins drive enable |
| bus_ad_in | input | BUS_W | Shared pins, incoming value |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| ack | output | 1 | Internal transfer acknowledge pulse |
| rd_data | output | BUS_W | Captured read data |

## Verification
Tick 1 is the first tick after the accepting edge. Every result is due at a fixed tick counted from there:

- latch enable in ticks 1 to 4·L
- chip select from tick 4·(L+S)+1
- strobe exactly 4 ticks after chip select
- `ack` on tick 4·(L+S+1+N)
- `req_ready` back after 4·(L+S+1+N+R) ticks
- `rd_data` valid from the tick after `ack`

The bench samples every output on the falling clock edge, half a tick away from the edge that changes it. It counts low and high ticks and records the first tick of each strobe, then compares these against the formulas.

It drives `bus_ad_in` with the expected read value only during the ack tick and with its complement in every other tick. A capture made one tick early or late therefore shows up as a wrong value.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETUP,
        ST_CSLEAD,
        ST_STROBE,
        ST_RECOVER
    } mcb_state_e;
endpackage

// File: rtl/mcb_phase_gen.sv
module mcb_phase_gen #(
    parameter int QUARTERS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_last
);
    localparam int PH_W = (QUARTERS > 1) ? $clog2(QUARTERS) : 1;
    localparam logic [PH_W-1:0] PH_END = PH_W'(QUARTERS - 1);

    logic [PH_W-1:0] phase_q;

    // Quarter counter: held at zero while idle, so an access begins on quarter 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || phase_q == PH_END) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    assign phase_last = (phase_q == PH_END);
endmodule

// File: rtl/mcb_seq_fsm.sv
module mcb_seq_fsm
    import mcb_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int SCY_W = 4,
    parameter int ALE_W = 2,
    parameter int SET_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic [SCY_W-1:0] cfg_wait_cnt,
    input  logic             cfg_relax,
    input  logic             cfg_early_neg,
    input  logic [ALE_W-1:0] cfg_ale_len,
    input  logic [SET_W-1:0] cfg_cs_setup,
    input  logic             phase_last,
    output mcb_state_e       state,
    output logic             run,
    output logic             str_last,
    output logic             lat_write,
    output logic             lat_csnt,
    output logic [BUS_W-1:0] lat_addr,
    output logic [BUS_W-1:0] lat_wdata
);
    localparam int MAX_W = (SCY_W > ALE_W) ? ((SCY_W > SET_W) ? SCY_W : SET_W)
                                           : ((ALE_W > SET_W) ? ALE_W : SET_W);
    localparam int CNT_W = MAX_W + 2;

    mcb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cyc_q, lim;
    logic [SCY_W-1:0] lat_scy;
    logic [ALE_W-1:0] lat_ale;
    logic [SET_W-1:0] lat_setup;
    logic             lat_relax;
    logic             accept, cyc_end;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Bus-cycle count that ends the current state
    always_comb begin
        unique case (state_q)
            ST_ADDR:   lim = CNT_W'(lat_ale) + CNT_W'(1);
            ST_SETUP:  lim = CNT_W'(lat_setup);
            ST_STROBE: lim = CNT_W'(lat_scy) + CNT_W'(lat_relax) + CNT_W'(1);
            default:   lim = CNT_W'(1);
        endcase
    end

    assign cyc_end = phase_last && (cyc_q == lim - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ADDR;
            ST_ADDR:    if (cyc_end) state_d = (lat_setup != '0) ? ST_SETUP : ST_CSLEAD;
            ST_SETUP:   if (cyc_end) state_d = ST_CSLEAD;
            ST_CSLEAD:  if (cyc_end) state_d = ST_STROBE;
            ST_STROBE:  if (cyc_end) state_d = lat_relax ? ST_RECOVER : ST_IDLE;
            ST_RECOVER: if (cyc_end) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and in-state bus-cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cyc_q <= '0;
            end else if (phase_last && state_q != ST_IDLE) begin
                cyc_q <= cyc_q + CNT_W'(1);
            end
        end
    end

    // Request and configuration captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_csnt  <= 1'b0;
            lat_relax <= 1'b0;
            lat_scy   <= '0;
            lat_ale   <= '0;
            lat_setup <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_write <= req_write;
            lat_csnt  <= cfg_early_neg;
            lat_relax <= cfg_relax;
            lat_scy   <= cfg_wait_cnt;
            lat_ale   <= cfg_ale_len;
            lat_setup <= cfg_cs_setup;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

    assign state    = state_q;
    assign run      = (state_q != ST_IDLE);
    assign str_last = (state_q == ST_STROBE) && (cyc_q == lim - CNT_W'(1));
endmodule

// File: rtl/mcb_pin_drive.sv
module mcb_pin_drive
    import mcb_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mcb_state_e       state,
    input  logic             phase_last,
    input  logic             str_last,
    input  logic             lat_write,
    input  logic             lat_csnt,
    input  logic [BUS_W-1:0] lat_addr,
    input  logic [BUS_W-1:0] lat_wdata,
    input  logic [BUS_W-1:0] bus_ad_in,
    output logic [BUS_W-1:0] bus_ad_out,
    output logic             bus_ad_oe,
    output logic             bus_cs_n,
    output logic             bus_ale,
    output logic             bus_oe_n,
    output logic             bus_we_n,
    output logic             ack,
    output logic             req_ready,
    output logic [BUS_W-1:0] rd_data
);
    logic             early_cut, in_strobe;
    logic [BUS_W-1:0] rd_q;

    // Output decode from state
    always_comb begin
        in_strobe  = (state == ST_STROBE);
        early_cut  = lat_write && lat_csnt && str_last && phase_last;
        ack        = str_last && phase_last;
        bus_ale    = (state == ST_ADDR);
        bus_cs_n   = !((state == ST_CSLEAD) || (in_strobe && !early_cut));
        bus_we_n   = !(in_strobe && lat_write && !early_cut);
        bus_oe_n   = !(in_strobe && !lat_write);
        bus_ad_oe  = (state == ST_ADDR) || (state == ST_SETUP) ||
                     (state == ST_CSLEAD) || (in_strobe && lat_write);
        bus_ad_out = in_strobe ? lat_wdata : lat_addr;
        req_ready  = (state == ST_IDLE);
    end

    // Read data taken at the end of the acknowledge tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (ack && !lat_write) begin
            rd_q <= bus_ad_in;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/mux_bus_cs_timer.sv
module mux_bus_cs_timer
    import mcb_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int SCY_W    = 4,
    parameter int ALE_W    = 2,
    parameter int SET_W    = 2,
    parameter int QUARTERS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             req_ready,
    input  logic [SCY_W-1:0] cfg_wait_cnt,
    input  logic             cfg_relax,
    input  logic             cfg_early_neg,
    input  logic [ALE_W-1:0] cfg_ale_len,
    input  logic [SET_W-1:0] cfg_cs_setup,
    output logic [BUS_W-1:0] bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [BUS_W-1:0] bus_ad_in,
    output logic             bus_cs_n,
    output logic             bus_ale,
    output logic             bus_oe_n,
    output logic             bus_we_n,
    output logic             ack,
    output logic [BUS_W-1:0] rd_data
);
    mcb_state_e       state;
    logic             run, phase_last, str_last, lat_write, lat_csnt;
    logic [BUS_W-1:0] lat_addr, lat_wdata;

    mcb_phase_gen #(.QUARTERS(QUARTERS)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .phase_last (phase_last)
    );

    mcb_seq_fsm #(.BUS_W(BUS_W), .SCY_W(SCY_W), .ALE_W(ALE_W), .SET_W(SET_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .cfg_wait_cnt  (cfg_wait_cnt),
        .cfg_relax     (cfg_relax),
        .cfg_early_neg (cfg_early_neg),
        .cfg_ale_len   (cfg_ale_len),
        .cfg_cs_setup  (cfg_cs_setup),
        .phase_last    (phase_last),
        .state         (state),
        .run           (run),
        .str_last      (str_last),
        .lat_write     (lat_write),
        .lat_csnt      (lat_csnt),
        .lat_addr      (lat_addr),
        .lat_wdata     (lat_wdata)
    );

    mcb_pin_drive #(.BUS_W(BUS_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .phase_last (phase_last),
        .str_last   (str_last),
        .lat_write  (lat_write),
        .lat_csnt   (lat_csnt),
        .lat_addr   (lat_addr),
        .lat_wdata  (lat_wdata),
        .bus_ad_in  (bus_ad_in),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_cs_n   (bus_cs_n),
        .bus_ale    (bus_ale),
        .bus_oe_n   (bus_oe_n),
        .bus_we_n   (bus_we_n),
        .ack        (ack),
        .req_ready  (req_ready),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/mcb_timing_chk.sv
module mcb_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_ale,
    input logic bus_cs_n,
    input logic bus_we_n,
    input logic bus_oe_n,
    input logic bus_ad_oe,
    input logic ack,
    input logic req_ready
);
    // R1
    ale_cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_cs_n && bus_ad_oe));

    // R3
    we_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_we_n) |-> ($past(!bus_cs_n, 4) && $past(bus_cs_n, 5)));

    // R4
    we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> (!bus_cs_n && bus_oe_n));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> !bus_ad_oe);

    // R6
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_ad_oe);

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R10
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_we_n && bus_oe_n && !bus_ale && !ack));
endmodule

bind mux_bus_cs_timer mcb_timing_chk u_timing_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ale   (bus_ale),
    .bus_cs_n  (bus_cs_n),
    .bus_we_n  (bus_we_n),
    .bus_oe_n  (bus_oe_n),
    .bus_ad_oe (bus_ad_oe),
    .ack       (ack),
    .req_ready (req_ready)
);

// File: tb/test_mux_bus_cs_timer.sv
`timescale 1ns/1ps
module test_mux_bus_cs_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0, bus_ad_in = '0;
    logic [3:0]  cfg_wait_cnt = '0;
    logic        cfg_relax = 1'b0, cfg_early_neg = 1'b0;
    logic [1:0]  cfg_ale_len = '0, cfg_cs_setup = '0;
    logic        req_ready, bus_ad_oe, bus_cs_n, bus_ale, bus_oe_n, bus_we_n, ack;
    logic [31:0] bus_ad_out, rd_data;

    int checks = 0, errors = 0, ticks_total = 0;
    logic [31:0] last_rv = '0;

    always #2 clk = ~clk;

    mux_bus_cs_timer i_mux_bus_cs_timer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .cfg_wait_cnt(cfg_wait_cnt), .cfg_relax(cfg_relax), .cfg_early_neg(cfg_early_neg),
        .cfg_ale_len(cfg_ale_len), .cfg_cs_setup(cfg_cs_setup),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .ack(ack), .rd_data(rd_data)
    );

    // {write, wait[3:0], relax, early_neg, ale_len[1:0], setup[1:0]}
    localparam logic [10:0] VEC [10] = '{
        {1'b1, 4'd0,  1'b0, 1'b0, 2'd0, 2'd0},
        {1'b1, 4'd2,  1'b0, 1'b1, 2'd1, 2'd0},
        {1'b1, 4'd5,  1'b1, 1'b0, 2'd3, 2'd1},
        {1'b1, 4'd3,  1'b1, 1'b1, 2'd0, 2'd2},
        {1'b1, 4'd15, 1'b1, 1'b1, 2'd2, 2'd3},
        {1'b0, 4'd0,  1'b0, 1'b0, 2'd0, 2'd0},
        {1'b0, 4'd4,  1'b0, 1'b1, 2'd1, 2'd1},
        {1'b0, 4'd6,  1'b1, 1'b0, 2'd3, 2'd0},
        {1'b0, 4'd1,  1'b1, 1'b1, 2'd2, 2'd2},
        {1'b1, 4'd7,  1'b0, 1'b0, 2'd1, 2'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        ticks_total++;
        if (ticks_total > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic run_access(input logic [10:0] v, input logic [31:0] a, input logic [31:0] d,
                              input logic [31:0] rv, input int poke);
        int wr, L, S, N, R, E, cut;
        int tick, n_ale, n_cs, n_we, n_oe, n_ack, n_drv, f_cs, f_str, t_ack;
        logic addr_ok, trans_ok, prev_oe;
        logic [31:0] prev_out;
        wr = int'(v[10]); N = int'(v[9:6]) + int'(v[5]) + 1; R = int'(v[5]);
        E = int'(v[4]); L = int'(v[3:2]) + 1; S = int'(v[1:0]);
        cut = wr & E;
        n_ale = 0; n_cs = 0; n_we = 0; n_oe = 0; n_ack = 0; n_drv = 0;
        f_cs = 0; f_str = 0; t_ack = 0; addr_ok = 1'b0; trans_ok = (wr == 0);
        prev_oe = 1'b0; prev_out = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = v[10]; req_addr = a; req_wdata = d;
        cfg_wait_cnt = v[9:6]; cfg_relax = v[5]; cfg_early_neg = v[4];
        cfg_ale_len = v[3:2]; cfg_cs_setup = v[1:0]; bus_ad_in = ~rv;
        @(negedge clk);
        req_valid = 1'b0;
        tick = 1;
        while (!req_ready && tick < 2000) begin
            if (tick == 1) addr_ok = bus_ale && bus_ad_oe && (bus_ad_out == a) && bus_cs_n;
            n_ale += int'(bus_ale);
            n_ack += int'(ack);
            n_drv += int'(bus_ad_oe);
            if (ack) t_ack = tick;
            if (!bus_cs_n) begin n_cs++; if (f_cs == 0) f_cs = tick; end
            if (!bus_we_n) n_we++;
            if (!bus_oe_n) n_oe++;
            if ((!bus_we_n || !bus_oe_n) && f_str == 0) begin
                f_str = tick;
                if (wr != 0)
                    trans_ok = prev_oe && (prev_out == a) && bus_ad_oe && (bus_ad_out == d);
            end
            prev_oe = bus_ad_oe; prev_out = bus_ad_out;
            bus_ad_in = ack ? rv : ~rv;
            req_valid = (tick == poke);
            if (tick == poke) begin req_addr = ~a; req_write = ~v[10]; end
            @(negedge clk);
            tick++;
        end
        req_valid = 1'b0;
        chk("R1 ale ticks", n_ale, 4 * L);
        chk("R1 address on pins at tick 1", {31'd0, addr_ok}, 1);
        chk("R2 first cs tick", f_cs, 4 * (L + S) + 1);
        chk("R3 strobe lag after cs", f_str - f_cs, 4);
        chk("R4 cs low ticks", n_cs, 4 + 4 * N - cut);
        if (wr != 0) begin
            chk("R4 we low ticks", n_we, 4 * N - E);
            chk("R6 drive ticks write", n_drv, 4 * (L + S + 1 + N));
            chk("R6 address to data handoff", {31'd0, trans_ok}, 1);
            chk("R5 oe idle on write", n_oe, 0);
        end else begin
            chk("R5 oe low ticks", n_oe, 4 * N);
            chk("R5 drive ticks read", n_drv, 4 * (L + S + 1));
            chk("R5 we idle on read", n_we, 0);
            last_rv = rv;
        end
        chk("R7 ack count", n_ack, 1);
        chk("R7 ack tick", t_ack, 4 * (L + S + 1 + N));
        chk("R9 busy ticks", tick - 1, 4 * (L + S + 1 + N + R));
        chk("R8 read data", rd_data, last_rv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state, sampled while reset is held
        chk("R11 ready", {31'd0, req_ready}, 1);
        chk("R11 cs_n", {31'd0, bus_cs_n}, 1);
        chk("R11 we_n", {31'd0, bus_we_n}, 1);
        chk("R11 oe_n", {31'd0, bus_oe_n}, 1);
        chk("R11 ale", {31'd0, bus_ale}, 0);
        chk("R11 ack", {31'd0, ack}, 0);
        chk("R11 drive", {31'd0, bus_ad_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            run_access(VEC[i], 32'hA000_0000 + 32'(i * 16), 32'h5A00_0000 + 32'(i),
                       32'hC0DE_0000 + 32'(i * 3), -1);
        end

        // R10: request raised while busy is ignored
        run_access({1'b1, 4'd2, 1'b0, 1'b1, 2'd1, 2'd1}, 32'h1234_5678, 32'h8765_4321,
                   32'h0, 2);
        begin
            int idle_act = 0;
            repeat (16) begin
                @(negedge clk);
                idle_act += int'(bus_ale) + int'(ack) + int'(!bus_cs_n);
            end
            chk("R10 no access after ignored request", idle_act, 0);
        end

        // R10 and R8: request on a read with poke, then read data across a write
        run_access({1'b0, 4'd3, 1'b1, 1'b0, 2'd0, 2'd0}, 32'h0F0F_0F0F, 32'h0,
                   32'hBEEF_CAFE, 5);
        run_access({1'b1, 4'd1, 1'b0, 1'b0, 2'd0, 2'd0}, 32'h2222_0000, 32'h3333_0000,
                   32'h0, -1);
        chk("R8 read data held across write", rd_data, 32'hBEEF_CAFE);

        finish_run();
    end
endmodule